// File: doc/BRIEF.md
# USB 1.1 Host Frame and Interrupt Controller

This block keeps the frame-level control state of a full-speed USB host controller: a command register, a status register, an interrupt-enable register, the 11-bit frame number and the frame-list base. While the controller is running it emits a frame tick every `TICK_CYC` clock cycles. It also presents the address of the frame-list entry for the current frame, which the schedule engine uses to fetch work for that frame.

The schedule engine reports completions and faults to this block as single-cycle pulses. Completion requests gathered during a frame are held back and only become visible at the next frame boundary. At that boundary they land in a hidden two-bit latch, so that completion-style and short-packet-style requests can be enabled separately even though both share one status bit. Software reaches the registers through a plain write-strobe and address port with combinational read data. A write with the controller-reset bit returns the block to its reset state in the next cycle.

Top module: `usbh_frame_ctrl`

## Requirements
- R1: After reset the status register reads 0x20 (only the halted bit set), every other register reads 0 and `irq_o` is low. Registers sit at byte offsets: base 0x0, command 0x4, status 0x6, enable 0x8, frame number 0xA. Any other offset reads 0 and ignores writes.
- R2: Command bit 0 is run. Writing it from 0 to 1 clears status bit 5 (halted) and starts the frame ticks. Writing it as 0 sets halted and stops the ticks. Halted always reads as the inverse of the run bit.
- R3: While running, `frame_tick_o` is high for one cycle out of every `TICK_CYC`. The first tick comes `TICK_CYC` edges after the edge that stored run. The frame number advances by one, modulo 2048, at each tick edge.
- R4: `frame_addr_o` equals the base plus the low 10 bits of the frame number times 4.
- R5: The base register keeps write bits 31:12, and its bits 11:0 always read 0.
- R6: A frame-number write takes effect only while halted and keeps bits 10:0. While running, the write is ignored.
- R7: Completion pulses (`ev_done`) and short-packet pulses (`ev_short`) stay pending until the next tick edge. At that edge they are OR'd into the hidden latch, with bit 0 for completion and bit 1 for short packet. Status bit 0 (interrupt) is set at that edge only if something was pending. A pulse in the tick cycle itself is included.
- R8: `irq_o` is high when any of these holds: latch bit 0 with enable bit 2; latch bit 1 with enable bit 3; status bit 1 with enable bit 0; status bit 2 with enable bit 1; status bit 3; status bit 4.
- R9: Writing 1 to a status bit in 0..4 clears it, and writing 1 to bit 0 also clears the hidden latch. A set in the same cycle wins over the clear. Bit 5 cannot be written.
- R10: A resume pulse while command bit 3 (global suspend) is set sets command bit 4 (force resume) and status bit 2. A resume pulse without bit 3 set changes nothing.
- R11: A command write with bit 1 set returns every register, the pending requests and the latch to their reset values at that edge. Command bit 1 always reads 0.
- R12: `bus_reset_o` follows command bit 2 (global reset).
- R13: An `ev_err` pulse sets status bit 1, `ev_sys_err` sets bit 3 and `ev_sched_err` sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data for `reg_addr` (combinational) |
| ev_done | input | 1 | Completion interrupt request pulse |
| ev_short | input | 1 | Short-packet interrupt request pulse |
| ev_err | input | 1 | Transfer error pulse |
| ev_resume | input | 1 | Remote resume pulse |
| ev_sys_err | input | 1 | Host system error pulse |
| ev_sched_err | input | 1 | Schedule process error pulse |
| frame_tick_o | output | 1 | One-cycle frame boundary strobe |
| frame_addr_o | output | AW | Address of current frame-list entry |
| irq_o | output | 1 | Interrupt line |
| bus_reset_o | output | 1 | Global bus reset drive |

## Verification
The bench targets four kinds of error, and each has a visible symptom:
- Deferral: a completion pulse that reached the status bit straight away, instead of at the next tick, would show up in the status read taken before that tick.
- Latch position: a design that swapped the two latch positions would raise `irq_o` with only the completion enable set after a short-packet pulse.
- Frame number: wrap from 0x7FF to 0 is checked, together with the ignored frame-number write while running. A design that let that write through, or got the wrap wrong, would show it in both the register read and `frame_addr_o`.
- Clearing: the random phase mixes status clears, run toggles, suspend and resume, and controller resets with event pulses in the same cycles. A design that let a clear win over a same-cycle set, or lost pending requests across a stop, would diverge from the bench model.

// File: rtl/usbh_frm_pkg.sv
// Package: shared offsets, bit positions and event bundle of the frame controller.
// Assumes byte-addressed registers; offsets below are the software-visible map.
package usbh_frm_pkg;

    // Register byte offsets
    localparam int unsigned OFS_BASE = 4'h0;
    localparam int unsigned OFS_CMD  = 4'h4;
    localparam int unsigned OFS_STS  = 4'h6;
    localparam int unsigned OFS_IEN  = 4'h8;
    localparam int unsigned OFS_FNUM = 4'hA;

    // Command bit positions
    localparam int unsigned CMD_RUN   = 0;
    localparam int unsigned CMD_HCRST = 1;
    localparam int unsigned CMD_GRST  = 2;
    localparam int unsigned CMD_SUSP  = 3;
    localparam int unsigned CMD_FRES  = 4;
    localparam int unsigned CMD_W     = 5;

    // Status flag positions (halted is derived separately at bit 5)
    localparam int unsigned ST_INT  = 0;
    localparam int unsigned ST_ERR  = 1;
    localparam int unsigned ST_RES  = 2;
    localparam int unsigned ST_SYS  = 3;
    localparam int unsigned ST_PROC = 4;
    localparam int unsigned ST_W    = 5;

    // Interrupt-enable bit positions
    localparam int unsigned IE_ERR   = 0;
    localparam int unsigned IE_RES   = 1;
    localparam int unsigned IE_DONE  = 2;
    localparam int unsigned IE_SHORT = 3;
    localparam int unsigned IE_W     = 4;

    // Event pulses from the schedule engine
    typedef struct packed {
        logic sched_err;
        logic sys_err;
        logic resume;
        logic xfer_err;
        logic short_pkt;
        logic done;
    } frm_evt_t;

endpackage

// File: rtl/usbh_frame_timer.sv
// Frame timer: counts TICK_CYC cycles while running and strobes a one-cycle tick.
// Assumes TICK_CYC >= 2; the count rests at zero while stopped so a restart
// always begins a full period.
module usbh_frame_timer #(
    parameter int unsigned TICK_CYC = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int unsigned CNT_W = $clog2(TICK_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Terminal count strobe while running
    assign tick = run && (cnt == LAST);

    // Cycle counter within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usbh_frame_index.sv
// Frame index: holds the frame number and the aligned frame-list base, and
// forms the address of the current frame-list entry.
// Assumes the caller only raises fnum_we while halted, so tick and write never meet.
module usbh_frame_index #(
    parameter int unsigned FNUM_W = 11,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned AW     = 32,
    parameter int unsigned ALIGN  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              fnum_we,
    input  logic [FNUM_W-1:0] fnum_wdata,
    input  logic              base_we,
    input  logic [AW-1:ALIGN] base_wdata,
    output logic [FNUM_W-1:0] fnum,
    output logic [AW-1:0]     base,
    output logic [AW-1:0]     entry_addr
);
    localparam int unsigned ENTRY_SHIFT = 2;

    logic [AW-1:ALIGN] base_hi;

    // Base keeps only its aligned upper bits
    assign base = {base_hi, {ALIGN{1'b0}}};

    // Entry address: base plus index times entry size
    assign entry_addr = base + AW'({fnum[IDX_W-1:0], {ENTRY_SHIFT{1'b0}}});

    // Frame number: advance at each tick, load while halted
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fnum <= '0;
        end else if (tick) begin
            fnum <= fnum + 1'b1;
        end else if (fnum_we) begin
            fnum <= fnum_wdata;
        end
    end

    // Frame-list base register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            base_hi <= '0;
        end else if (base_we) begin
            base_hi <= base_wdata;
        end
    end
endmodule

// File: rtl/usbh_irq_unit.sv
// Interrupt unit: gathers completion requests during a frame, moves them into a
// hidden two-bit latch at the frame boundary, keeps the sticky status flags and
// forms the interrupt line. Assumes w1c is already decoded to the status write.
module usbh_irq_unit
    import usbh_frm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            tick,
    input  frm_evt_t        ev,
    input  logic            susp,
    input  logic [ST_W-1:0] w1c,
    input  logic [IE_W-1:0] ien,
    output logic [ST_W-1:0] flags,
    output logic            irq
);
    logic [1:0] pend;
    logic [1:0] latch;
    logic [1:0] pend_all;

    // Requests of this frame including this cycle's pulses
    assign pend_all = pend | {ev.short_pkt, ev.done};

    // Interrupt line from latch, flags and enables
    assign irq = (latch[0] & ien[IE_DONE]) | (latch[1] & ien[IE_SHORT]) |
                 (flags[ST_ERR] & ien[IE_ERR]) | (flags[ST_RES] & ien[IE_RES]) |
                 flags[ST_SYS] | flags[ST_PROC];

    // Pending requests and hidden latch
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend  <= '0;
            latch <= '0;
        end else begin
            pend  <= tick ? 2'b00 : pend_all;
            latch <= (w1c[ST_INT] ? 2'b00 : latch) | (tick ? pend_all : 2'b00);
        end
    end

    // Sticky status flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else begin
            flags[ST_INT]  <= (flags[ST_INT]  & ~w1c[ST_INT])  | (tick & (|pend_all));
            flags[ST_ERR]  <= (flags[ST_ERR]  & ~w1c[ST_ERR])  | ev.xfer_err;
            flags[ST_RES]  <= (flags[ST_RES]  & ~w1c[ST_RES])  | (ev.resume & susp);
            flags[ST_SYS]  <= (flags[ST_SYS]  & ~w1c[ST_SYS])  | ev.sys_err;
            flags[ST_PROC] <= (flags[ST_PROC] & ~w1c[ST_PROC]) | ev.sched_err;
        end
    end
endmodule

// File: rtl/usbh_frame_ctrl.sv
// Top: register decode, command register and readback for the USB 1.1 host
// frame and interrupt controller. Assumes single-cycle register writes and
// combinational reads; a command write with the reset bit clears the block.
module usbh_frame_ctrl
    import usbh_frm_pkg::*;
#(
    parameter int unsigned TICK_CYC = 12000,
    parameter int unsigned FNUM_W   = 11,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned AW       = 32,
    parameter int unsigned ALIGN    = 12,
    parameter int unsigned RA_W     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [AW-1:0]   reg_wdata,
    output logic [AW-1:0]   reg_rdata,
    input  logic            ev_done,
    input  logic            ev_short,
    input  logic            ev_err,
    input  logic            ev_resume,
    input  logic            ev_sys_err,
    input  logic            ev_sched_err,
    output logic            frame_tick_o,
    output logic [AW-1:0]   frame_addr_o,
    output logic            irq_o,
    output logic            bus_reset_o
);
    logic [CMD_W-1:0]  cmd_q;
    logic [IE_W-1:0]   ien_q;
    logic [ST_W-1:0]   flags;
    logic [ST_W-1:0]   w1c;
    logic [FNUM_W-1:0] fnum;
    logic [AW-1:0]     base;
    logic              run;
    logic              hc_clr;
    logic              wr_cmd, wr_sts, wr_ien, wr_fnum, wr_base;
    frm_evt_t          ev;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata[ALIGN-1:FNUM_W];

    // Write decode
    assign wr_cmd  = reg_we && (reg_addr == RA_W'(OFS_CMD));
    assign wr_sts  = reg_we && (reg_addr == RA_W'(OFS_STS));
    assign wr_ien  = reg_we && (reg_addr == RA_W'(OFS_IEN));
    assign wr_fnum = reg_we && (reg_addr == RA_W'(OFS_FNUM));
    assign wr_base = reg_we && (reg_addr == RA_W'(OFS_BASE));

    assign hc_clr = wr_cmd && reg_wdata[CMD_HCRST];
    assign run    = cmd_q[CMD_RUN];
    assign w1c    = wr_sts ? reg_wdata[ST_W-1:0] : '0;
    assign ev     = '{sched_err: ev_sched_err, sys_err: ev_sys_err, resume: ev_resume,
                      xfer_err: ev_err, short_pkt: ev_short, done: ev_done};

    assign bus_reset_o = cmd_q[CMD_GRST];

    // Command register, reset bit never stored
    always_ff @(posedge clk) begin
        if (!rst_n || hc_clr) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= reg_wdata[CMD_W-1:0] & ~(CMD_W'(1) << CMD_HCRST);
        end else if (ev_resume && cmd_q[CMD_SUSP]) begin
            cmd_q[CMD_FRES] <= 1'b1;
        end
    end

    // Interrupt-enable register
    always_ff @(posedge clk) begin
        if (!rst_n || hc_clr) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= reg_wdata[IE_W-1:0];
        end
    end

    usbh_frame_timer #(.TICK_CYC(TICK_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hc_clr),
        .run   (run),
        .tick  (frame_tick_o)
    );

    usbh_frame_index #(
        .FNUM_W(FNUM_W), .IDX_W(IDX_W), .AW(AW), .ALIGN(ALIGN)
    ) u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (hc_clr),
        .tick       (frame_tick_o),
        .fnum_we    (wr_fnum && !run),
        .fnum_wdata (reg_wdata[FNUM_W-1:0]),
        .base_we    (wr_base),
        .base_wdata (reg_wdata[AW-1:ALIGN]),
        .fnum       (fnum),
        .base       (base),
        .entry_addr (frame_addr_o)
    );

    usbh_irq_unit u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hc_clr),
        .tick  (frame_tick_o),
        .ev    (ev),
        .susp  (cmd_q[CMD_SUSP]),
        .w1c   (w1c),
        .ien   (ien_q),
        .flags (flags),
        .irq   (irq_o)
    );

    // Read multiplexer, halted shown as the inverse of run
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_W'(OFS_BASE): reg_rdata = base;
            RA_W'(OFS_CMD):  reg_rdata = AW'(cmd_q);
            RA_W'(OFS_STS):  reg_rdata = AW'({~run, flags});
            RA_W'(OFS_IEN):  reg_rdata = AW'(ien_q);
            RA_W'(OFS_FNUM): reg_rdata = AW'(fnum);
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usbh_frame_ctrl_chk.sv
// Checker: temporal properties of the frame controller, bound to the top.
// Assumes it sees the top's run, reset-write, frame number and status flags.
module usbh_frame_ctrl_chk #(
    parameter int unsigned FNUM_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hc_clr,
    input logic              run,
    input logic              frame_tick_o,
    input logic              irq_o,
    input logic [FNUM_W-1:0] fnum,
    input logic [4:0]        flags
);
    p_no_tick_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !frame_tick_o);

    p_fnum_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick_o && !hc_clr) |=> (fnum == FNUM_W'($past(fnum) + 1'b1)));

    p_fnum_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !frame_tick_o && !hc_clr) |=> $stable(fnum));

    p_int_at_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(frame_tick_o));

    p_fatal_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[3] || flags[4]) |-> irq_o);

    p_hc_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hc_clr |=> (!run && fnum == '0 && flags == '0 && !irq_o));
endmodule

bind usbh_frame_ctrl usbh_frame_ctrl_chk #(.FNUM_W(FNUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hc_clr       (hc_clr),
    .run          (run),
    .frame_tick_o (frame_tick_o),
    .irq_o        (irq_o),
    .fnum         (fnum),
    .flags        (flags)
);

// File: tb/tb_usbh_frame_ctrl.sv
`timescale 1ns/1ps
module tb_usbh_frame_ctrl;
    localparam int TICK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_done = 0, ev_short = 0, ev_err = 0, ev_resume = 0;
    logic        ev_sys_err = 0, ev_sched_err = 0;
    logic        frame_tick_o, irq_o, bus_reset_o;
    logic [31:0] frame_addr_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    usbh_frame_ctrl #(.TICK_CYC(TICK)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
        .ev_short(ev_short), .ev_err(ev_err), .ev_resume(ev_resume),
        .ev_sys_err(ev_sys_err), .ev_sched_err(ev_sched_err),
        .frame_tick_o(frame_tick_o), .frame_addr_o(frame_addr_o),
        .irq_o(irq_o), .bus_reset_o(bus_reset_o));

    // Reference model state (from the requirements)
    logic [4:0]  m_cmd;
    logic [4:0]  m_flags;
    logic [1:0]  m_latch, m_pend;
    logic [3:0]  m_ien;
    logic [10:0] m_fnum;
    logic [31:0] m_base;
    int          m_cnt;

    function automatic void m_reset();
        m_cmd = '0; m_flags = '0; m_latch = '0; m_pend = '0;
        m_ien = '0; m_fnum = '0; m_base = '0; m_cnt = 0;
    endfunction

    function automatic logic m_tick();
        return m_cmd[0] && (m_cnt == TICK - 1);
    endfunction

    function automatic logic [31:0] m_addr();
        return m_base + {20'd0, m_fnum[9:0], 2'b00};
    endfunction

    function automatic logic m_irq();
        return (m_latch[0] & m_ien[2]) | (m_latch[1] & m_ien[3]) |
               (m_flags[1] & m_ien[0]) | (m_flags[2] & m_ien[1]) |
               m_flags[3] | m_flags[4];
    endfunction

    function automatic logic [31:0] m_rd(input logic [3:0] a);
        case (a)
            4'h0: return m_base;
            4'h4: return {27'd0, m_cmd};
            4'h6: return {26'd0, ~m_cmd[0], m_flags};
            4'h8: return {28'd0, m_ien};
            4'hA: return {21'd0, m_fnum};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'h0: return "R5 base read";
            4'h4: return "R2 command read";
            4'h6: return "R9 status read";
            4'h8: return "R8 enable read";
            4'hA: return "R6 frame number read";
            default: return "R1 unmapped read";
        endcase
    endfunction

    // Advance the model by one clock edge with the given inputs
    function automatic void m_step(input logic we, input logic [3:0] a,
                                   input logic [31:0] d, input logic [5:0] ev);
        logic tk;
        logic [1:0] pa;
        logic [4:0] w;
        logic [4:0] ncmd;
        tk = m_tick();
        if (we && a == 4'h4 && d[1]) begin
            m_reset();
            return;
        end
        pa = m_pend | ev[1:0];
        w  = (we && a == 4'h6) ? d[4:0] : 5'd0;
        ncmd = m_cmd;
        if (we && a == 4'h4) ncmd = d[4:0] & 5'b11101;
        else if (ev[3] && m_cmd[3]) ncmd[4] = 1'b1;
        if (!m_cmd[0] || tk) m_cnt = 0; else m_cnt = m_cnt + 1;
        if (tk) m_fnum = m_fnum + 11'd1;
        else if (we && a == 4'hA && !m_cmd[0]) m_fnum = d[10:0];
        if (we && a == 4'h0) m_base = {d[31:12], 12'd0};
        if (we && a == 4'h8) m_ien = d[3:0];
        m_latch = (w[0] ? 2'b00 : m_latch) | (tk ? pa : 2'b00);
        m_pend  = tk ? 2'b00 : pa;
        m_flags[0] = (m_flags[0] & ~w[0]) | (tk & (|pa));
        m_flags[1] = (m_flags[1] & ~w[1]) | ev[2];
        m_flags[2] = (m_flags[2] & ~w[2]) | (ev[3] & m_cmd[3]);
        m_flags[3] = (m_flags[3] & ~w[3]) | ev[4];
        m_flags[4] = (m_flags[4] & ~w[4]) | ev[5];
        m_cmd = ncmd;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check outputs against the model, advance
    // ev bits: {sched_err, sys_err, resume, err, short, done}
    task automatic cycx(input logic we, input logic [3:0] a, input logic [31:0] d,
                        input logic [5:0] ev, input string tag,
                        input logic [31:0] exp, input bit xchk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        {ev_sched_err, ev_sys_err, ev_resume, ev_err, ev_short, ev_done} = ev;
        #1;
        chk("R3 frame tick", {31'd0, frame_tick_o}, {31'd0, m_tick()});
        chk("R4 entry address", frame_addr_o, m_addr());
        chk("R8 irq line", {31'd0, irq_o}, {31'd0, m_irq()});
        chk("R12 bus reset", {31'd0, bus_reset_o}, {31'd0, m_cmd[2]});
        chk(rd_tag(a), reg_rdata, m_rd(a));
        if (xchk) chk(tag, reg_rdata, exp);
        m_step(we, a, d, ev);
        @(negedge clk);
    endtask

    task automatic idle();
        cycx(1'b0, 4'h0, 32'd0, 6'd0, "", 32'd0, 1'b0);
    endtask
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cycx(1'b1, a, d, 6'd0, "", 32'd0, 1'b0);
    endtask
    task automatic pulse(input logic [5:0] ev);
        cycx(1'b0, 4'h0, 32'd0, ev, "", 32'd0, 1'b0);
    endtask
    task automatic peek(input logic [3:0] a, input string tag, input logic [31:0] exp);
        cycx(1'b0, a, 32'd0, 6'd0, tag, exp, 1'b1);
    endtask
    task automatic wait_tick();
        for (int i = 0; i < 4 * TICK && !frame_tick_o; i++) idle();
        idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(4'h6, "R1 status after reset", 32'h20);
        peek(4'h4, "R1 command after reset", 32'h0);
        peek(4'hA, "R1 frame number after reset", 32'h0);
        peek(4'h8, "R1 enable after reset", 32'h0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);

        // R5 base alignment, R4 address
        wr(4'h0, 32'hFFFF_FFFF);
        peek(4'h0, "R5 base low bits zero", 32'hFFFF_F000);
        chk("R4 address at frame 0", frame_addr_o, 32'hFFFF_F000);

        // R6 frame number write while halted keeps 11 bits
        wr(4'hA, 32'h0000_FFFF);
        peek(4'hA, "R6 halted frame write", 32'h7FF);
        chk("R4 address uses 10 index bits", frame_addr_o, 32'hFFFF_FFFC);

        // R2 run, R7 deferral, R3 wrap
        wr(4'h8, 32'hF);
        wr(4'h4, 32'h1);
        peek(4'h6, "R2 halted cleared by run", 32'h0);
        pulse(6'b000001);
        peek(4'h6, "R7 completion deferred", 32'h0);
        chk("R7 no irq before boundary", {31'd0, irq_o}, 32'd0);
        wait_tick();
        peek(4'hA, "R3 frame number wraps", 32'h0);
        peek(4'h6, "R7 interrupt at boundary", 32'h01);
        chk("R8 irq from completion latch", {31'd0, irq_o}, 32'd1);
        wr(4'hA, 32'h123);
        peek(4'hA, "R6 write ignored while running", 32'h0);

        // R9 clear
        wr(4'h6, 32'h1);
        peek(4'h6, "R9 interrupt cleared", 32'h0);
        chk("R9 irq low after clear", {31'd0, irq_o}, 32'd0);

        // R7 short packet lands in latch bit 1
        wr(4'h8, 32'h4);
        pulse(6'b000010);
        wait_tick();
        peek(4'h6, "R7 short sets interrupt", 32'h01);
        chk("R7 short not in completion slot", {31'd0, irq_o}, 32'd0);
        wr(4'h8, 32'h8);
        chk("R8 short enable raises irq", {31'd0, irq_o}, 32'd1);
        wr(4'h6, 32'h1);

        // R13 error, R8 enable, R9 clear
        pulse(6'b000100);
        peek(4'h6, "R13 error flag", 32'h02);
        chk("R8 error masked", {31'd0, irq_o}, 32'd0);
        wr(4'h8, 32'h1);
        chk("R8 error enabled", {31'd0, irq_o}, 32'd1);
        wr(4'h6, 32'h2);
        peek(4'h6, "R9 error cleared", 32'h0);

        // R10 resume
        pulse(6'b001000);
        peek(4'h4, "R10 resume ignored (command)", 32'h1);
        peek(4'h6, "R10 resume ignored (status)", 32'h0);
        wr(4'h4, 32'h9);
        pulse(6'b001000);
        peek(4'h4, "R10 force resume set", 32'h19);
        peek(4'h6, "R10 resume detect set", 32'h04);
        wr(4'h6, 32'h4);

        // R12 global reset drive
        wr(4'h4, 32'h0D);
        chk("R12 bus reset high", {31'd0, bus_reset_o}, 32'd1);
        wr(4'h4, 32'h01);
        chk("R12 bus reset low", {31'd0, bus_reset_o}, 32'd0);

        // R13 fatal flags, R8 unmasked
        wr(4'h8, 32'h0);
        pulse(6'b010000);
        peek(4'h6, "R13 system error flag", 32'h08);
        chk("R8 system error unmasked", {31'd0, irq_o}, 32'd1);
        pulse(6'b100000);
        peek(4'h6, "R13 process error flag", 32'h18);

        // R2 stop
        wr(4'h4, 32'h0);
        peek(4'h6, "R2 halted set by stop", 32'h38);
        for (int i = 0; i < 3 * TICK; i++) begin
            idle();
            chk("R2 no tick while halted", {31'd0, frame_tick_o}, 32'd0);
        end

        // R11 controller reset
        wr(4'h4, 32'h3);
        peek(4'h4, "R11 command cleared", 32'h0);
        peek(4'h6, "R11 status reset", 32'h20);
        peek(4'h0, "R11 base reset", 32'h0);
        peek(4'hA, "R11 frame number reset", 32'h0);
        chk("R11 irq low", {31'd0, irq_o}, 32'd0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [3:0]  a;
            logic [31:0] d;
            logic [5:0]  ev;
            we = ($urandom % 6) == 0;
            a  = 4'($urandom % 16);
            if (($urandom % 2) == 0) a = {a[3:1], 1'b0} & 4'hE;
            d  = $urandom;
            if (a == 4'h4) begin
                d[1] = ($urandom % 64) == 0;
                d[0] = ($urandom % 8) != 0;
            end
            ev[0] = ($urandom % 12) == 0;
            ev[1] = ($urandom % 12) == 0;
            ev[2] = ($urandom % 20) == 0;
            ev[3] = ($urandom % 16) == 0;
            ev[4] = ($urandom % 150) == 0;
            ev[5] = ($urandom % 150) == 0;
            cycx(we, a, d, ev, "", 32'd0, 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule